// File: doc/BRIEF.md
# Parallel DAC Write Strobe Sequencer

This block sits on the host side of a parallel, double-buffered digital-to-analog converter bus. It accepts write commands over a valid/ready handshake. Each command holds a channel number, a signed two's complement sample and a flag. The block turns the sample into the converter's offset binary code. It drives the channel address and the data word, then generates the chip-select and write strobes. When the flag is set, it also generates a load strobe after the write. All strobes are active low and come from registers.

All timing minimums are given in nanoseconds as parameters and converted to clock cycles from the clock period. Each conversion rounds up and never drops below one cycle. Several channels can be written without the flag, and the last write can carry the flag. One load pulse then moves every channel's input latch into its output latch at the same instant. The load pulse starts only after a fixed gap following the rise of chip select. This keeps the converter's deglitch circuit from triggering on data that is still moving.

A second handshake port requests a clear pulse of programmable length. That pulse is timed by its own unit, so it can overlap a write without changing that write's strobes.

Top module: `dac_strobe_seq`

## Requirements
- R1: The data word of a write is the sample with bit 12 (the most significant bit) inverted, the same as adding 4096 modulo 8192. For example, -4096 gives 0x0000, 0 gives 0x1000, 4095 gives 0x1FFF and -1 gives 0x0FFF.
- R2: The address equals the command's channel. Address and data are driven one cycle before chip select falls, and both stay stable for as long as chip select and write are low.
- R3: Chip select and write fall together one cycle after acceptance and rise together. They stay low for the largest of the cycle counts for the 50 ns strobe width, the 50 ns data setup and the 15 ns address setup. Each count is ceil(t/period) with a minimum of 1, which gives 13 cycles at the defaults.
- R4: Write is never low while chip select is high.
- R5: When the load flag is set, load falls a gap count of cycles after chip select rises (50 ns, 13 cycles at the defaults) and stays low for the 50 ns load width (13 cycles). Load is never low while write is low.
- R6: When the load flag is clear, no load pulse is produced.
- R7: Command ready falls on acceptance and rises on the same edge as the command's last strobe. At the defaults, the count of cycles with ready low is 14 without a load and 40 with a load.
- R8: A clear request drives the clear strobe low for max(length, 1) cycles starting at acceptance. Clear ready stays low for exactly those cycles.
- R9: A clear that overlaps a write leaves that write's address, data, strobe widths and load timing unchanged.
- R10: During and right after reset, all strobes are high, both ready outputs are high, and address and data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Write command offered |
| cmd_ready | output | 1 | Write command accepted when high with cmd_valid |
| cmd_chan | input | CH_W | Target channel |
| cmd_sample | input | DW | Signed two's complement sample |
| cmd_load | input | 1 | Generate a load pulse after this write |
| clr_valid | input | 1 | Clear request offered |
| clr_ready | output | 1 | Clear request accepted when high with clr_valid |
| clr_len | input | LEN_W | Clear hold length in cycles (0 treated as 1) |
| dac_addr | output | CH_W | Channel address to the converter |
| dac_data | output | DW | Offset binary data word |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_wr_n | output | 1 | Write strobe, active low |
| dac_ld_n | output | 1 | Load strobe, active low |
| dac_clr_n | output | 1 | Clear strobe, active low |

## Verification
A wrong cycle counter in the write sequencer appears at the very next strobe edge: the chip-select run, the gap or the load run comes out one or more cycles off, and the busy count seen on ready is off by the same amount. A wrong state transition appears as a load pulse with no flag, a missing load pulse, or ready coming back while a strobe is still low, all within one command. A fault in the sign conversion or the address capture appears as a wrong data or address word, sampled at the rising edge of chip select. A clear unit that shares state with the writer would change the overlapping write's widths, so those widths are compared against the expected values in the same command.

// File: rtl/dss_pkg.sv
package dss_pkg;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_ADDR,
    WS_LOW,
    WS_GAP,
    WS_LOAD
  } wr_state_t;

endpackage

// File: rtl/dss_fmt.sv
module dss_fmt #(
  parameter int DW = 13
) (
  input  logic [DW-1:0] sample,
  output logic [DW-1:0] code
);
  // offset binary: flip the sign bit, pass the rest
  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i == DW - 1) begin : g_msb
      assign code[i] = ~sample[i];
    end else begin : g_low
      assign code[i] = sample[i];
    end
  end
endmodule

// File: rtl/dss_wr_fsm.sv
module dss_wr_fsm
  import dss_pkg::*;
#(
  parameter int DW      = 13,
  parameter int CH_W    = 3,
  parameter int LOW_CYC = 13,
  parameter int GAP_CYC = 13,
  parameter int LD_CYC  = 13,
  parameter int CNT_W   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [CH_W-1:0] cmd_chan,
  input  logic [DW-1:0]   cmd_code,
  input  logic            cmd_load,
  output logic [CH_W-1:0] addr,
  output logic [DW-1:0]   data,
  output logic            cs_n,
  output logic            wr_n,
  output logic            ld_n
);
  wr_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic             ld_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= WS_IDLE;
      cmd_ready <= 1'b1;
      addr      <= '0;
      data      <= '0;
      cs_n      <= 1'b1;
      wr_n      <= 1'b1;
      ld_n      <= 1'b1;
      cnt       <= '0;
      ld_req    <= 1'b0;
    end else begin
      case (state)
        WS_IDLE: begin
          if (cmd_valid && cmd_ready) begin
            addr      <= cmd_chan;
            data      <= cmd_code;
            ld_req    <= cmd_load;
            cmd_ready <= 1'b0;
            state     <= WS_ADDR;
          end
        end
        WS_ADDR: begin
          cs_n  <= 1'b0;
          wr_n  <= 1'b0;
          cnt   <= CNT_W'(LOW_CYC - 1);
          state <= WS_LOW;
        end
        WS_LOW: begin
          if (cnt == '0) begin
            cs_n <= 1'b1;
            wr_n <= 1'b1;
            if (ld_req) begin
              cnt   <= CNT_W'(GAP_CYC - 1);
              state <= WS_GAP;
            end else begin
              cmd_ready <= 1'b1;
              state     <= WS_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        WS_GAP: begin
          if (cnt == '0) begin
            ld_n  <= 1'b0;
            cnt   <= CNT_W'(LD_CYC - 1);
            state <= WS_LOAD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        WS_LOAD: begin
          if (cnt == '0) begin
            ld_n      <= 1'b1;
            cmd_ready <= 1'b1;
            state     <= WS_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= WS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dss_clr_hold.sv
module dss_clr_hold #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LEN_W-1:0] req_len,
  output logic             clr_n
);
  logic [LEN_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready <= 1'b1;
      clr_n     <= 1'b1;
      left      <= '0;
    end else if (req_ready) begin
      if (req_valid) begin
        req_ready <= 1'b0;
        clr_n     <= 1'b0;
        left      <= (req_len == '0) ? '0 : req_len - 1'b1;
      end
    end else if (left == '0) begin
      req_ready <= 1'b1;
      clr_n     <= 1'b1;
    end else begin
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/dac_strobe_seq.sv
module dac_strobe_seq
  import dss_pkg::*;
#(
  parameter int CLK_NS     = 4,
  parameter int T_STROBE_NS = 50,
  parameter int T_DSU_NS   = 50,
  parameter int T_ASU_NS   = 15,
  parameter int T_GAP_NS   = 50,
  parameter int T_LD_NS    = 50,
  parameter int CH_W       = 3,
  parameter int DW         = 13,
  parameter int LEN_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [CH_W-1:0]  cmd_chan,
  input  logic [DW-1:0]    cmd_sample,
  input  logic             cmd_load,
  input  logic             clr_valid,
  output logic             clr_ready,
  input  logic [LEN_W-1:0] clr_len,
  output logic [CH_W-1:0]  dac_addr,
  output logic [DW-1:0]    dac_data,
  output logic             dac_cs_n,
  output logic             dac_wr_n,
  output logic             dac_ld_n,
  output logic             dac_clr_n
);
  localparam int LOW_CYC = max3(ns_to_cyc(T_STROBE_NS, CLK_NS),
                                ns_to_cyc(T_DSU_NS, CLK_NS),
                                ns_to_cyc(T_ASU_NS, CLK_NS));
  localparam int GAP_CYC = ns_to_cyc(T_GAP_NS, CLK_NS);
  localparam int LD_CYC  = ns_to_cyc(T_LD_NS, CLK_NS);
  localparam int MAX_CYC = max3(LOW_CYC, GAP_CYC, LD_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [DW-1:0] code;

  dss_fmt #(.DW(DW)) u_fmt (
    .sample (cmd_sample),
    .code   (code)
  );

  dss_wr_fsm #(
    .DW(DW), .CH_W(CH_W), .LOW_CYC(LOW_CYC), .GAP_CYC(GAP_CYC),
    .LD_CYC(LD_CYC), .CNT_W(CNT_W)
  ) u_wr (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_chan  (cmd_chan),
    .cmd_code  (code),
    .cmd_load  (cmd_load),
    .addr      (dac_addr),
    .data      (dac_data),
    .cs_n      (dac_cs_n),
    .wr_n      (dac_wr_n),
    .ld_n      (dac_ld_n)
  );

  dss_clr_hold #(.LEN_W(LEN_W)) u_clr (
    .clk       (clk),
    .rst       (rst),
    .req_valid (clr_valid),
    .req_ready (clr_ready),
    .req_len   (clr_len),
    .clr_n     (dac_clr_n)
  );
endmodule

// File: rtl/dac_strobe_seq_chk.sv
module dac_strobe_seq_chk #(
  parameter int CH_W    = 3,
  parameter int DW      = 13,
  parameter int LOW_CYC = 13,
  parameter int GAP_CYC = 13,
  parameter int LD_CYC  = 13
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_ready,
  input logic            clr_ready,
  input logic [CH_W-1:0] dac_addr,
  input logic [DW-1:0]   dac_data,
  input logic            dac_cs_n,
  input logic            dac_wr_n,
  input logic            dac_ld_n,
  input logic            dac_clr_n
);
  logic [15:0] cs_run, ld_run, since_cs;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_run   <= '0;
      ld_run   <= '0;
      since_cs <= '0;
    end else begin
      cs_run   <= dac_cs_n ? '0 : ((cs_run == 16'hFFFF) ? cs_run : cs_run + 1'b1);
      ld_run   <= dac_ld_n ? '0 : ((ld_run == 16'hFFFF) ? ld_run : ld_run + 1'b1);
      since_cs <= !dac_cs_n ? '0 : ((since_cs == 16'hFFFF) ? since_cs : since_cs + 1'b1);
    end
  end

  p_stable_bus_r2: assert property (@(posedge clk) disable iff (rst)
    (!dac_cs_n && !dac_wr_n && $past(!dac_cs_n && !dac_wr_n))
      |-> ($stable(dac_addr) && $stable(dac_data)));

  p_cs_width_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_cs_n) |-> (cs_run >= 16'(LOW_CYC)));

  p_wr_inside_cs_r4: assert property (@(posedge clk) disable iff (rst)
    !dac_wr_n |-> !dac_cs_n);

  p_ld_gap_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(dac_ld_n) |-> (since_cs >= 16'(GAP_CYC)));

  p_ld_width_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_ld_n) |-> (ld_run >= 16'(LD_CYC)));

  p_ld_not_in_wr_r5: assert property (@(posedge clk) disable iff (rst)
    !dac_wr_n |-> dac_ld_n);

  p_busy_while_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    (!dac_cs_n || !dac_ld_n) |-> !cmd_ready);

  p_clr_busy_r8: assert property (@(posedge clk) disable iff (rst)
    !dac_clr_n |-> !clr_ready);
endmodule

bind dac_strobe_seq dac_strobe_seq_chk #(
  .CH_W(CH_W), .DW(DW), .LOW_CYC(LOW_CYC), .GAP_CYC(GAP_CYC), .LD_CYC(LD_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_ready (cmd_ready),
  .clr_ready (clr_ready),
  .dac_addr  (dac_addr),
  .dac_data  (dac_data),
  .dac_cs_n  (dac_cs_n),
  .dac_wr_n  (dac_wr_n),
  .dac_ld_n  (dac_ld_n),
  .dac_clr_n (dac_clr_n)
);

// File: tb/dac_strobe_seq_test.sv
`timescale 1ns/1ps
module dac_strobe_seq_test;
  localparam int EXP_LOW  = 13;
  localparam int EXP_GAP  = 13;
  localparam int EXP_LD   = 13;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_chan = '0;
  logic [12:0] cmd_sample = '0;
  logic        cmd_load = 1'b0;
  logic        clr_valid = 1'b0;
  logic        clr_ready;
  logic [15:0] clr_len = '0;
  logic [2:0]  dac_addr;
  logic [12:0] dac_data;
  logic        dac_cs_n, dac_wr_n, dac_ld_n, dac_clr_n;

  always #2 clk = ~clk;

  dac_strobe_seq uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_chan(cmd_chan), .cmd_sample(cmd_sample), .cmd_load(cmd_load),
    .clr_valid(clr_valid), .clr_ready(clr_ready), .clr_len(clr_len),
    .dac_addr(dac_addr), .dac_data(dac_data), .dac_cs_n(dac_cs_n),
    .dac_wr_n(dac_wr_n), .dac_ld_n(dac_ld_n), .dac_clr_n(dac_clr_n)
  );

  typedef struct {
    logic [2:0]  ch;
    logic [12:0] code;
  } wr_item_t;

  wr_item_t q_wr[$];
  int       q_ld[$];
  int       q_clr[$];
  int checks = 0;
  int errors = 0;
  int viol_wr = 0;
  int viol_ld = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // driver: push expectation, handshake, measure busy cycles (R7)
  task automatic do_write(input logic [2:0] ch, input int sample, input bit load);
    wr_item_t it;
    int busy;
    it.ch   = ch;
    it.code = 13'(sample + 4096);
    q_wr.push_back(it);
    if (load) q_ld.push_back(1);
    @(negedge clk);
    cmd_valid  = 1'b1;
    cmd_chan   = ch;
    cmd_sample = 13'(sample);
    cmd_load   = load;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    busy = 0;
    forever begin
      @(negedge clk);
      if (cmd_ready) break;
      busy++;
    end
    check(busy == (load ? 40 : 14), "R7", "ready-low cycles", busy, load ? 40 : 14);
  endtask

  task automatic do_clr(input int len);
    int busy;
    int exp_len;
    exp_len = (len == 0) ? 1 : len;
    q_clr.push_back(exp_len);
    @(negedge clk);
    clr_valid = 1'b1;
    clr_len   = 16'(len);
    while (!clr_ready) @(negedge clk);
    @(posedge clk);
    #1 clr_valid = 1'b0;
    busy = 0;
    forever begin
      @(negedge clk);
      if (clr_ready) break;
      busy++;
    end
    check(busy == exp_len, "R8", "clear ready-low cycles", busy, exp_len);
  endtask

  // monitor: pops expectations as strobe edges appear
  initial begin
    logic p_cs = 1'b1, p_ld = 1'b1, p_clr = 1'b1;
    int cs_run = 0, wr_run = 0, ld_run = 0, clr_run = 0, gap = 0, gap_at_fall = 0;
    logic [2:0]  addr_low = '0;
    logic [12:0] data_low = '0;
    wr_item_t it;
    int e;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (!dac_wr_n && dac_cs_n) viol_wr++;
        if (!dac_wr_n && !dac_ld_n) viol_ld++;
        if (!dac_cs_n) begin
          if (cs_run > 0 && (dac_addr != addr_low || dac_data != data_low))
            check(0, "R2", "bus moved while strobes low", dac_data, data_low);
          addr_low = dac_addr;
          data_low = dac_data;
          cs_run++;
        end
        if (!dac_wr_n) wr_run++;
        if (!dac_cs_n) gap = 0;
        else if (dac_ld_n) gap++;
        if (!dac_ld_n) ld_run++;
        if (!dac_clr_n) clr_run++;
        if (p_ld && !dac_ld_n) gap_at_fall = gap;

        if (!p_cs && dac_cs_n) begin
          if (q_wr.size() == 0) begin
            check(0, "R6", "unexpected write", 1, 0);
          end else begin
            it = q_wr.pop_front();
            check(dac_addr == it.ch, "R2", "address", dac_addr, it.ch);
            check(dac_data == it.code, "R1", "data code", dac_data, it.code);
            check(cs_run == EXP_LOW, "R3", "cs low cycles", cs_run, EXP_LOW);
            check(wr_run == EXP_LOW, "R3", "wr low cycles", wr_run, EXP_LOW);
          end
          cs_run = 0;
          wr_run = 0;
        end
        if (!p_ld && dac_ld_n) begin
          if (q_ld.size() == 0) begin
            check(0, "R6", "load pulse without flag", 1, 0);
          end else begin
            e = q_ld.pop_front();
            check(gap_at_fall == EXP_GAP, "R5", "cs-rise to load-fall gap", gap_at_fall, EXP_GAP);
            check(ld_run == EXP_LD, "R5", "load low cycles", ld_run, EXP_LD);
          end
          ld_run = 0;
        end
        if (!p_clr && dac_clr_n) begin
          if (q_clr.size() == 0) begin
            check(0, "R8", "unexpected clear", 1, 0);
          end else begin
            e = q_clr.pop_front();
            check(clr_run == e, "R8", "clear low cycles", clr_run, e);
          end
          clr_run = 0;
        end
      end
      p_cs  = dac_cs_n;
      p_ld  = dac_ld_n;
      p_clr = dac_clr_n;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(dac_cs_n && dac_wr_n && dac_ld_n && dac_clr_n, "R10", "strobes in reset",
          {dac_cs_n, dac_wr_n, dac_ld_n, dac_clr_n}, 15);
    #1 rst = 1'b0;
    @(negedge clk);
    check(cmd_ready && clr_ready, "R10", "ready after reset", {cmd_ready, clr_ready}, 3);
    check(dac_addr == 0 && dac_data == 0, "R10", "bus after reset", dac_data, 0);
    check(dac_cs_n && dac_wr_n && dac_ld_n && dac_clr_n, "R10", "strobes after reset",
          {dac_cs_n, dac_wr_n, dac_ld_n, dac_clr_n}, 15);

    // batch without load (R6), then shared load on last (R5)
    do_write(3'd0, -4096, 1'b0);
    do_write(3'd1, 0, 1'b0);
    do_write(3'd2, 4095, 1'b0);
    do_write(3'd7, -1, 1'b1);
    do_write(3'd5, 1234, 1'b1);
    do_write(3'd4, -2000, 1'b0);

    // clear overlapping a write with load (R9)
    fork
      do_write(3'd3, -77, 1'b1);
      begin
        repeat (5) @(negedge clk);
        do_clr(20);
      end
    join
    do_clr(0);
    do_clr(3);
    fork
      do_clr(60);
      do_write(3'd6, 100, 1'b0);
    join

    repeat (5) @(negedge clk);
    check(q_wr.size() == 0, "R9", "writes left unseen", q_wr.size(), 0);
    check(q_ld.size() == 0, "R5", "loads left unseen", q_ld.size(), 0);
    check(q_clr.size() == 0, "R8", "clears left unseen", q_clr.size(), 0);
    check(viol_wr == 0, "R4", "write low with cs high", viol_wr, 0);
    check(viol_ld == 0, "R5", "load low with write low", viol_ld, 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule